// File: doc/BRIEF.md
# Counter Clock and Gate Routing Matrix

This block selects where each timer channel in a group of counter banks takes its clock and its gate from. The banks sit in a ring, and each bank holds three channels. Every channel has a stored 3-bit clock-select code and a 3-bit gate-select code. A simple write port loads both codes for one channel in a single cycle. A read port returns the stored codes of whichever channel it addresses.

The clock of a channel can come from its own external clock pin, from one of five fixed reference clocks, from the bank's shared external clock, or from the output of the channel before it in the chain. The gate of a channel can be tied low, tied high, taken from its own external gate pin, or taken from an inverted channel output at a fixed offset. Both the chained clock and the inverted-output gate cross bank boundaries, and the last bank wraps round to the first.

The routed outputs are purely combinational from the stored codes. A new selection is therefore visible on the routed outputs from the cycle that follows the write edge. The counters themselves, the host address decoding and any input synchronisers belong to the surrounding logic.

Top module: `ctr_route_matrix`

## Requirements
- R1: After reset, every channel holds clock code 0 and gate code 2.
- R2: On a rising clock edge with `wr_en` high and `wr_addr` below the channel count, the addressed channel stores `wr_clk_sel` and `wr_gate_sel`. The routed outputs change only after that edge; before it they still follow the old codes.
- R3: A write whose `wr_addr` is not below the channel count changes no channel. A read whose `rd_addr` is not below the channel count returns 0 for both codes.
- R4: Channel i is bit i of every per-channel vector, with i = 3*bank + position. Clock code 0 routes `pin_clk[i]`. Codes 1 to 5 route `ref_clk[code-1]`. Code 7 routes `grp_ext_clk[bank]`.
- R5: Clock code 6 routes the output of the previous channel. Position 1 or 2 takes `ch_out[i-1]`. Position 0 takes position 2 of the preceding bank, and the preceding bank of bank 0 is the last bank. In flat numbering, channel 0 takes `ch_out[last]`.
- R6: Gate code 0 routes constant 0 and code 1 routes constant 1. Code 2 routes `pin_gate[i]`. Codes 4 to 7 route constant 0.
- R7: Gate code 3 routes an inverted channel output. Position 2 takes the inverse of position 0 in the same bank. Positions 0 and 1 take the inverse of position (n+1) in the preceding bank, wrapping from bank 0 to the last bank.
- R8: The read port is combinational. `rd_clk_sel` and `rd_gate_sel` show the stored codes of channel `rd_addr` in the same cycle that `rd_addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the select codes |
| wr_addr | input | ADDR_W | Channel to write |
| wr_clk_sel | input | 3 | Clock-select code to store |
| wr_gate_sel | input | 3 | Gate-select code to store |
| rd_addr | input | ADDR_W | Channel to read back |
| rd_clk_sel | output | 3 | Stored clock code of the read channel |
| rd_gate_sel | output | 3 | Stored gate code of the read channel |
| pin_clk | input | NCH | Dedicated external clock pin per channel |
| pin_gate | input | NCH | Dedicated external gate pin per channel |
| grp_ext_clk | input | NUM_GRP | Shared external clock per bank |
| ch_out | input | NCH | Output of each counter channel |
| ref_clk | input | 5 | Fixed internal reference clocks |
| mux_clk | output | NCH | Routed clock per channel |
| mux_gate | output | NCH | Routed gate per channel |

## Verification
The hardest cases to reach are the routes that cross the ring wrap. Clock code 6 on channel 0 must pick the last channel of the last bank, and gate code 3 on positions 0 and 1 of bank 0 must pick outputs of the last bank. A random write stream hits these only now and then, so directed writes put those exact codes on the wrap channels. Each of those channel outputs is then toggled by itself and the result checked. A random mix of writes then follows, including writes to addresses past the last channel. After every step the bench checks every routed output against a model of the ring rules, with random pin and output patterns.

// File: rtl/ctr_route_pkg.sv
package ctr_route_pkg;

    localparam int CH_PER_GRP = 3;
    localparam int SEL_W      = 3;
    localparam int NUM_REF    = 5;

    typedef logic [SEL_W-1:0] sel_t;

    typedef struct packed {
        sel_t clk_sel;
        sel_t gate_sel;
    } chan_cfg_t;

    localparam sel_t CLK_PIN    = 3'd0;
    localparam sel_t CLK_CHAIN  = 3'd6;
    localparam sel_t CLK_GRPEXT = 3'd7;

    localparam sel_t GATE_LOW   = 3'd0;
    localparam sel_t GATE_HIGH  = 3'd1;
    localparam sel_t GATE_PIN   = 3'd2;
    localparam sel_t GATE_INV   = 3'd3;

    // flat index of the channel feeding the chained clock of channel idx
    function automatic int chain_src(input int idx, input int nch);
        return (idx + nch - 1) % nch;
    endfunction

    // flat index of the channel whose inverted output gates channel idx
    function automatic int inv_src(input int idx, input int ngrp);
        int pos;
        int grp;
        int prv;
        pos = idx % CH_PER_GRP;
        grp = idx / CH_PER_GRP;
        prv = (grp + ngrp - 1) % ngrp;
        if (pos == CH_PER_GRP - 1) return grp * CH_PER_GRP;
        return prv * CH_PER_GRP + pos + 1;
    endfunction

endpackage

// File: rtl/ctr_route_cfg.sv
module ctr_route_cfg
    import ctr_route_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int ADDR_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  chan_cfg_t             wr_cfg,
    input  logic [ADDR_W-1:0]     rd_addr,
    output chan_cfg_t             rd_cfg,
    output chan_cfg_t [NCH-1:0]   cfg_all
);

    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(NCH - 1);
    localparam chan_cfg_t RST_CFG = '{clk_sel: CLK_PIN, gate_sel: GATE_PIN};

    chan_cfg_t [NCH-1:0] cfg_q;

    for (genvar i = 0; i < NCH; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[i] <= RST_CFG;
            end else if (wr_en && wr_addr == ADDR_W'(i)) begin
                cfg_q[i] <= wr_cfg;
            end
        end
    end

    always_comb begin
        rd_cfg = '0;
        if (rd_addr <= LAST_A) begin
            rd_cfg = cfg_q[rd_addr];
        end
    end

    assign cfg_all = cfg_q;

endmodule

// File: rtl/ctr_route_clkmux.sv
module ctr_route_clkmux
    import ctr_route_pkg::*;
#(
    parameter int NUM_GRP = 2,
    parameter int NCH     = NUM_GRP * CH_PER_GRP
) (
    input  chan_cfg_t [NCH-1:0]   cfg_all,
    input  logic [NCH-1:0]        pin_clk,
    input  logic [NUM_GRP-1:0]    grp_ext_clk,
    input  logic [NCH-1:0]        ch_out,
    input  logic [NUM_REF-1:0]    ref_clk,
    output logic [NCH-1:0]        mux_clk
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int GRP = i / CH_PER_GRP;
        localparam int SRC = chain_src(i, NCH);

        always_comb begin
            unique case (cfg_all[i].clk_sel)
                CLK_PIN:    mux_clk[i] = pin_clk[i];
                CLK_CHAIN:  mux_clk[i] = ch_out[SRC];
                CLK_GRPEXT: mux_clk[i] = grp_ext_clk[GRP];
                3'd1:       mux_clk[i] = ref_clk[0];
                3'd2:       mux_clk[i] = ref_clk[1];
                3'd3:       mux_clk[i] = ref_clk[2];
                3'd4:       mux_clk[i] = ref_clk[3];
                default:    mux_clk[i] = ref_clk[4];
            endcase
        end
    end

endmodule

// File: rtl/ctr_route_gatemux.sv
module ctr_route_gatemux
    import ctr_route_pkg::*;
#(
    parameter int NUM_GRP = 2,
    parameter int NCH     = NUM_GRP * CH_PER_GRP
) (
    input  chan_cfg_t [NCH-1:0]   cfg_all,
    input  logic [NCH-1:0]        pin_gate,
    input  logic [NCH-1:0]        ch_out,
    output logic [NCH-1:0]        mux_gate
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int SRC = inv_src(i, NUM_GRP);

        always_comb begin
            unique case (cfg_all[i].gate_sel)
                GATE_LOW:  mux_gate[i] = 1'b0;
                GATE_HIGH: mux_gate[i] = 1'b1;
                GATE_PIN:  mux_gate[i] = pin_gate[i];
                GATE_INV:  mux_gate[i] = ~ch_out[SRC];
                default:   mux_gate[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/ctr_route_matrix.sv
module ctr_route_matrix
    import ctr_route_pkg::*;
#(
    parameter int NUM_GRP = 2,
    parameter int NCH     = NUM_GRP * CH_PER_GRP,
    parameter int ADDR_W  = $clog2(NCH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [SEL_W-1:0]      wr_clk_sel,
    input  logic [SEL_W-1:0]      wr_gate_sel,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [SEL_W-1:0]      rd_clk_sel,
    output logic [SEL_W-1:0]      rd_gate_sel,
    input  logic [NCH-1:0]        pin_clk,
    input  logic [NCH-1:0]        pin_gate,
    input  logic [NUM_GRP-1:0]    grp_ext_clk,
    input  logic [NCH-1:0]        ch_out,
    input  logic [NUM_REF-1:0]    ref_clk,
    output logic [NCH-1:0]        mux_clk,
    output logic [NCH-1:0]        mux_gate
);

    chan_cfg_t             wr_cfg;
    chan_cfg_t             rd_cfg;
    chan_cfg_t [NCH-1:0]   cfg_all;

    assign wr_cfg = '{clk_sel: wr_clk_sel, gate_sel: wr_gate_sel};

    ctr_route_cfg #(
        .NCH    (NCH),
        .ADDR_W (ADDR_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_cfg  (wr_cfg),
        .rd_addr (rd_addr),
        .rd_cfg  (rd_cfg),
        .cfg_all (cfg_all)
    );

    ctr_route_clkmux #(
        .NUM_GRP (NUM_GRP),
        .NCH     (NCH)
    ) u_clkmux (
        .cfg_all     (cfg_all),
        .pin_clk     (pin_clk),
        .grp_ext_clk (grp_ext_clk),
        .ch_out      (ch_out),
        .ref_clk     (ref_clk),
        .mux_clk     (mux_clk)
    );

    ctr_route_gatemux #(
        .NUM_GRP (NUM_GRP),
        .NCH     (NCH)
    ) u_gatemux (
        .cfg_all  (cfg_all),
        .pin_gate (pin_gate),
        .ch_out   (ch_out),
        .mux_gate (mux_gate)
    );

    assign rd_clk_sel  = rd_cfg.clk_sel;
    assign rd_gate_sel = rd_cfg.gate_sel;

endmodule

// File: rtl/ctr_route_chk.sv
module ctr_route_chk
    import ctr_route_pkg::*;
#(
    parameter int NUM_GRP = 2,
    parameter int NCH     = NUM_GRP * CH_PER_GRP,
    parameter int ADDR_W  = $clog2(NCH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [SEL_W-1:0]      wr_clk_sel,
    input  logic [SEL_W-1:0]      wr_gate_sel,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [SEL_W-1:0]      rd_clk_sel,
    input  logic [SEL_W-1:0]      rd_gate_sel,
    input  logic [NCH-1:0]        pin_clk,
    input  logic [NCH-1:0]        pin_gate,
    input  logic [NUM_GRP-1:0]    grp_ext_clk,
    input  logic [NCH-1:0]        ch_out,
    input  logic [NUM_REF-1:0]    ref_clk,
    input  logic [NCH-1:0]        mux_clk,
    input  logic [NCH-1:0]        mux_gate
);

    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(NCH - 1);

    // R2: a valid write is seen on the read port one cycle later
    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr <= LAST_A) |=>
            (rd_addr != $past(wr_addr)) ||
            (rd_clk_sel == $past(wr_clk_sel) && rd_gate_sel == $past(wr_gate_sel)));

    // R3: reads beyond the last channel return zero codes
    a_r3_oob_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr > LAST_A) |-> (rd_clk_sel == '0 && rd_gate_sel == '0));

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        localparam int CSRC = (k == 0) ? NCH - 1 : k - 1;
        localparam int GSRC = inv_src(k, NUM_GRP);
        localparam logic [ADDR_W-1:0] KA = ADDR_W'(k);

        // R4
        a_r4_clk_pin: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_addr == KA && rd_clk_sel == 3'd0) |-> mux_clk[k] == pin_clk[k]);
        // R4
        a_r4_clk_grp: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_addr == KA && rd_clk_sel == 3'd7) |-> mux_clk[k] == grp_ext_clk[k / CH_PER_GRP]);
        // R5
        a_r5_clk_chain: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_addr == KA && rd_clk_sel == 3'd6) |-> mux_clk[k] == ch_out[CSRC]);
        // R6
        a_r6_gate_pin: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_addr == KA && rd_gate_sel == 3'd2) |-> mux_gate[k] == pin_gate[k]);
        // R6
        a_r6_gate_const: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_addr == KA && rd_gate_sel != 3'd2 && rd_gate_sel != 3'd3) |->
                mux_gate[k] == (rd_gate_sel == 3'd1));
        // R7
        a_r7_gate_inv: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_addr == KA && rd_gate_sel == 3'd3) |-> mux_gate[k] == !ch_out[GSRC]);
    end

endmodule

bind ctr_route_matrix ctr_route_chk #(
    .NUM_GRP (NUM_GRP),
    .NCH     (NCH),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_clk_sel  (wr_clk_sel),
    .wr_gate_sel (wr_gate_sel),
    .rd_addr     (rd_addr),
    .rd_clk_sel  (rd_clk_sel),
    .rd_gate_sel (rd_gate_sel),
    .pin_clk     (pin_clk),
    .pin_gate    (pin_gate),
    .grp_ext_clk (grp_ext_clk),
    .ch_out      (ch_out),
    .ref_clk     (ref_clk),
    .mux_clk     (mux_clk),
    .mux_gate    (mux_gate)
);

// File: tb/ctr_route_matrix_bench.sv
module ctr_route_matrix_bench;

    localparam int NUM_GRP = 2;
    localparam int NCH     = NUM_GRP * 3;
    localparam int ADDR_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [2:0]        wr_clk_sel = '0;
    logic [2:0]        wr_gate_sel = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [2:0]        rd_clk_sel;
    logic [2:0]        rd_gate_sel;
    logic [NCH-1:0]    pin_clk = '0;
    logic [NCH-1:0]    pin_gate = '0;
    logic [NUM_GRP-1:0] grp_ext_clk = '0;
    logic [NCH-1:0]    ch_out = '0;
    logic [4:0]        ref_clk = '0;
    logic [NCH-1:0]    mux_clk;
    logic [NCH-1:0]    mux_gate;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [2:0] sh_clk  [NCH];
    logic [2:0] sh_gate [NCH];

    always #5ns clk = ~clk;

    ctr_route_matrix #(.NUM_GRP(NUM_GRP)) u_ctr_route_matrix (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_clk_sel(wr_clk_sel), .wr_gate_sel(wr_gate_sel), .rd_addr(rd_addr),
        .rd_clk_sel(rd_clk_sel), .rd_gate_sel(rd_gate_sel), .pin_clk(pin_clk),
        .pin_gate(pin_gate), .grp_ext_clk(grp_ext_clk), .ch_out(ch_out),
        .ref_clk(ref_clk), .mux_clk(mux_clk), .mux_gate(mux_gate)
    );

    function automatic logic exp_clk(input int i);
        case (sh_clk[i])
            3'd0: return pin_clk[i];
            3'd6: return (i == 0) ? ch_out[NCH-1] : ch_out[i-1];
            3'd7: return grp_ext_clk[i/3];
            default: return ref_clk[int'(sh_clk[i]) - 1];
        endcase
    endfunction

    function automatic logic exp_gate(input int i);
        int pos, grp, prv;
        pos = i % 3;
        grp = i / 3;
        prv = (grp == 0) ? NUM_GRP - 1 : grp - 1;
        case (sh_gate[i])
            3'd1: return 1'b1;
            3'd2: return pin_gate[i];
            3'd3: return (pos == 2) ? !ch_out[grp*3] : !ch_out[prv*3 + pos + 1];
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_routes(input string tag);
        #1;
        for (int i = 0; i < NCH; i++) begin
            check({tag, " clk route"}, 8'(mux_clk[i]), 8'(exp_clk(i)));
            check({tag, " gate route"}, 8'(mux_gate[i]), 8'(exp_gate(i)));
        end
    endtask

    task automatic check_readback(input string tag);
        for (int i = 0; i < 8; i++) begin
            rd_addr = 3'(i);
            #1;
            if (i < NCH) begin
                check({tag, " R8 rd clk"}, 8'(rd_clk_sel), 8'(sh_clk[i]));
                check({tag, " R8 rd gate"}, 8'(rd_gate_sel), 8'(sh_gate[i]));
            end else begin
                check("R3 oob read", 8'({rd_clk_sel, rd_gate_sel}), 8'h00);
            end
        end
    endtask

    task automatic rand_inputs();
        pin_clk     = NCH'($urandom);
        pin_gate    = NCH'($urandom);
        grp_ext_clk = NUM_GRP'($urandom);
        ch_out      = NCH'($urandom);
        ref_clk     = 5'($urandom);
    endtask

    // write at the next rising edge; routes must not move before it (R2)
    task automatic do_write(input int a, input logic [2:0] c, input logic [2:0] g);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_clk_sel = c; wr_gate_sel = g;
        check_routes("R2 pre-edge");
        @(negedge clk);
        wr_en = 1'b0;
        if (a < NCH) begin
            sh_clk[a] = c;
            sh_gate[a] = g;
        end
        check_routes(a < NCH ? "R2 post-edge" : "R3 ignored write");
    endtask

    initial begin
        #(100000 * 10ns);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < NCH; i++) begin
            sh_clk[i] = 3'd0;
            sh_gate[i] = 3'd2;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: defaults after reset
        check_readback("R1");
        rand_inputs();
        check_routes("R1 R4 R6 default");

        // R5 ring wrap: channel 0 chained from the last channel
        do_write(0, 3'd6, 3'd3);
        for (int b = 0; b < NCH; b++) begin
            ch_out = NCH'(1) << b;
            check_routes("R5 R7 wrap walk");
        end
        // R7 positions 1 and 2 of bank 0, position 2 of bank 1
        do_write(1, 3'd6, 3'd3);
        do_write(2, 3'd7, 3'd3);
        do_write(5, 3'd7, 3'd3);
        do_write(3, 3'd6, 3'd1);
        for (int b = 0; b < NCH; b++) begin
            ch_out = ~(NCH'(1) << b);
            check_routes("R5 R7 inverted walk");
        end
        // R4 reference codes
        for (int c = 1; c <= 5; c++) begin
            do_write(4, 3'(c), 3'(c + 2));
            ref_clk = 5'(1) << (c - 1);
            check_routes("R4 R6 ref sweep");
        end
        // R3 writes past the last channel change nothing
        do_write(6, 3'd5, 3'd5);
        do_write(7, 3'd1, 3'd0);
        check_readback("R3 after oob");

        for (int n = 0; n < 300; n++) begin
            do_write(int'($urandom_range(7, 0)), 3'($urandom), 3'($urandom));
            rand_inputs();
            check_routes("R4 R5 R6 R7 random");
            if (n % 25 == 0) check_readback("R2 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule